// File: doc/BRIEF.md
# MD5 Block Compression Engine

This engine runs the MD5 compression function over 512-bit message blocks. Each block arrives as sixteen 32-bit words on a request/acknowledge word port. The engine keeps the four 32-bit chaining words from one block to the next. A start-of-message strobe loads the standard initial chaining values. When a block ends, the engine adds its working result into the chaining state word by word. After the block that carries the final flag, it raises a ready flag.

Padding and length insertion are done upstream, so every block fed to the engine is already complete. The first round's sixteen steps take message words in their arrival order. Each of those steps therefore runs in the same cycle that its word is captured. The other 48 steps read the words back from a local store, one step per cycle, and one more cycle does the chaining addition. The busy window after the last word of a block is therefore always 49 enabled cycles.

Top module: `md5_compress`

## Requirements
- R1: While `rst_n` is low, `req` is 1, `ready` is 0 and all four digest outputs are 0. The reset acts asynchronously, and the internal release is synchronised to `clk`.
- R2: A cycle with `en` and `init` high loads the digest outputs with A=67452301h, B=EFCDAB89h, C=98BADCFEh and D=10325476h. The same cycle clears `ready`, discards any partly loaded block and leaves `req` at 1.
- R3: While `req` is high, a word is captured at each enabled rising edge where `ack` is high. While `req` is low, `ack` and `word_in` have no effect on the digest.
- R4: `req` goes low after the edge that captures the sixteenth word of a block. It returns high exactly 49 enabled clock edges later.
- R5: At the end of each block, each of the four working words is added modulo 2^32 to the matching chaining word. The sum becomes the new chaining state, so a multi-block message yields its MD5 digest.
- R6: `ready` rises in the same cycle as `req` after a block whose sixteenth word was captured with `last_blk` high. It stays high, with the digest unchanged, until the next `init`. A block captured with `last_blk` low leaves `ready` at 0.
- R7: While `en` is low, every register holds its value. The 49-cycle busy window is lengthened by the number of disabled cycles.
- R8: The compression uses the MD5 step functions, the 64 sine-derived additive constants, the per-round rotate amounts and the per-round word-index order. The empty message gives A=D98C1DD4h, B=04B2008Fh, C=980980E9h and D=7E42F8ECh.
- R9: Each input word is little-endian, with the earliest message byte in bits 7:0. The digest words use the same order, so "abc" gives A=98500190h, B=B04FD23Ch, C=7D3F96D6h and D=727FE128h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable; low freezes all state |
| init | input | 1 | Start-of-message strobe; loads the initial chaining values |
| ack | input | 1 | Word strobe; `word_in` is captured while `req` is high |
| word_in | input | 32 | Message word, little-endian byte order |
| last_blk | input | 1 | Marks the final block; sampled with the sixteenth word |
| req | output | 1 | Engine can accept words |
| ready | output | 1 | Digest of the finished message is valid |
| dig_a | output | 32 | Chaining/digest word A |
| dig_b | output | 32 | Chaining/digest word B |
| dig_c | output | 32 | Chaining/digest word C |
| dig_d | output | 32 | Chaining/digest word D |

## Verification
The digest outputs change only at the chaining addition or at `init`. A wrong constant, rotate amount, word index or step function therefore stays hidden until the end of the block, 49 enabled cycles after the last word. It then shows up as an avalanche of wrong bits in all four words, and a known-answer compare catches it at once. A miscounted step or load counter shows up earlier and more cheaply: `req` returns on the wrong cycle, or a later word is not captured. A chaining fault that a single block cannot reveal needs a multi-block message. A fault in the sticky ready flag shows up as `ready` falling before `init`.

// File: rtl/md5_pkg.sv
`timescale 1ns/1ps
package md5_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 16;
  localparam int NSTEPS  = 64;
  localparam int STEP_W  = $clog2(NSTEPS);
  localparam int WIDX_W  = $clog2(NWORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_FOLD} phase_e;

  localparam quad_t SEED = '{a: 32'h67452301, b: 32'hefcdab89,
                             c: 32'h98badcfe, d: 32'h10325476};

  // additive constant per step: integer part of |sin(i+1)| * 2^32
  function automatic word_t step_const(input logic [STEP_W-1:0] i);
    case (i)
      6'd0:  step_const = 32'hd76aa478;  6'd1:  step_const = 32'he8c7b756;
      6'd2:  step_const = 32'h242070db;  6'd3:  step_const = 32'hc1bdceee;
      6'd4:  step_const = 32'hf57c0faf;  6'd5:  step_const = 32'h4787c62a;
      6'd6:  step_const = 32'ha8304613;  6'd7:  step_const = 32'hfd469501;
      6'd8:  step_const = 32'h698098d8;  6'd9:  step_const = 32'h8b44f7af;
      6'd10: step_const = 32'hffff5bb1;  6'd11: step_const = 32'h895cd7be;
      6'd12: step_const = 32'h6b901122;  6'd13: step_const = 32'hfd987193;
      6'd14: step_const = 32'ha679438e;  6'd15: step_const = 32'h49b40821;
      6'd16: step_const = 32'hf61e2562;  6'd17: step_const = 32'hc040b340;
      6'd18: step_const = 32'h265e5a51;  6'd19: step_const = 32'he9b6c7aa;
      6'd20: step_const = 32'hd62f105d;  6'd21: step_const = 32'h02441453;
      6'd22: step_const = 32'hd8a1e681;  6'd23: step_const = 32'he7d3fbc8;
      6'd24: step_const = 32'h21e1cde6;  6'd25: step_const = 32'hc33707d6;
      6'd26: step_const = 32'hf4d50d87;  6'd27: step_const = 32'h455a14ed;
      6'd28: step_const = 32'ha9e3e905;  6'd29: step_const = 32'hfcefa3f8;
      6'd30: step_const = 32'h676f02d9;  6'd31: step_const = 32'h8d2a4c8a;
      6'd32: step_const = 32'hfffa3942;  6'd33: step_const = 32'h8771f681;
      6'd34: step_const = 32'h6d9d6122;  6'd35: step_const = 32'hfde5380c;
      6'd36: step_const = 32'ha4beea44;  6'd37: step_const = 32'h4bdecfa9;
      6'd38: step_const = 32'hf6bb4b60;  6'd39: step_const = 32'hbebfbc70;
      6'd40: step_const = 32'h289b7ec6;  6'd41: step_const = 32'heaa127fa;
      6'd42: step_const = 32'hd4ef3085;  6'd43: step_const = 32'h04881d05;
      6'd44: step_const = 32'hd9d4d039;  6'd45: step_const = 32'he6db99e5;
      6'd46: step_const = 32'h1fa27cf8;  6'd47: step_const = 32'hc4ac5665;
      6'd48: step_const = 32'hf4292244;  6'd49: step_const = 32'h432aff97;
      6'd50: step_const = 32'hab9423a7;  6'd51: step_const = 32'hfc93a039;
      6'd52: step_const = 32'h655b59c3;  6'd53: step_const = 32'h8f0ccc92;
      6'd54: step_const = 32'hffeff47d;  6'd55: step_const = 32'h85845dd1;
      6'd56: step_const = 32'h6fa87e4f;  6'd57: step_const = 32'hfe2ce6e0;
      6'd58: step_const = 32'ha3014314;  6'd59: step_const = 32'h4e0811a1;
      6'd60: step_const = 32'hf7537e82;  6'd61: step_const = 32'hbd3af235;
      6'd62: step_const = 32'h2ad7d2bb;  default: step_const = 32'heb86d391;
    endcase
  endfunction

  // left-rotate amount: depends on the round and on the step within a group of four
  function automatic logic [4:0] rot_amt(input logic [STEP_W-1:0] i);
    case ({i[5:4], i[1:0]})
      4'h0: rot_amt = 5'd7;   4'h1: rot_amt = 5'd12;
      4'h2: rot_amt = 5'd17;  4'h3: rot_amt = 5'd22;
      4'h4: rot_amt = 5'd5;   4'h5: rot_amt = 5'd9;
      4'h6: rot_amt = 5'd14;  4'h7: rot_amt = 5'd20;
      4'h8: rot_amt = 5'd4;   4'h9: rot_amt = 5'd11;
      4'hA: rot_amt = 5'd16;  4'hB: rot_amt = 5'd23;
      4'hC: rot_amt = 5'd6;   4'hD: rot_amt = 5'd10;
      4'hE: rot_amt = 5'd15;  default: rot_amt = 5'd21;
    endcase
  endfunction

  // message word used by a step; arithmetic wraps modulo 16
  function automatic logic [WIDX_W-1:0] word_sel(input logic [STEP_W-1:0] i);
    logic [WIDX_W-1:0] j;
    j = i[WIDX_W-1:0];
    case (i[5:4])
      2'd0:    word_sel = j;
      2'd1:    word_sel = j * 4'd5 + 4'd1;
      2'd2:    word_sel = j * 4'd3 + 4'd5;
      default: word_sel = j * 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/md5_msg_store.sv
`timescale 1ns/1ps
module md5_msg_store #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem_q[g] <= '0;
      else if (en && we && waddr == g)   mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/md5_step.sv
`timescale 1ns/1ps
module md5_step
  import md5_pkg::*;
(
  input  quad_t             cur,
  input  word_t             msg,
  input  logic [STEP_W-1:0] idx,
  output quad_t             nxt
);
  word_t       fmix, sum;
  logic [4:0]  sh;
  logic [2*WORD_W-1:0] dbl;

  always_comb begin
    case (idx[5:4])
      2'd0:    fmix = (cur.b & cur.c) | (~cur.b & cur.d);
      2'd1:    fmix = (cur.d & cur.b) | (~cur.d & cur.c);
      2'd2:    fmix = cur.b ^ cur.c ^ cur.d;
      default: fmix = cur.c ^ (cur.b | ~cur.d);
    endcase
    sum = cur.a + fmix + step_const(idx) + msg;
    sh  = rot_amt(idx);
    dbl = {sum, sum} << sh;
    nxt.a = cur.d;
    nxt.b = cur.b + dbl[2*WORD_W-1:WORD_W];
    nxt.c = cur.b;
    nxt.d = cur.c;
  end
endmodule

// File: rtl/md5_compress.sv
`timescale 1ns/1ps
module md5_compress
  import md5_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        init,
  input  logic        ack,
  input  logic [31:0] word_in,
  input  logic        last_blk,
  output logic        req,
  output logic        ready,
  output logic [31:0] dig_a,
  output logic [31:0] dig_b,
  output logic [31:0] dig_c,
  output logic [31:0] dig_d
);
  localparam logic [STEP_W-1:0] LAST_LOAD = STEP_W'(NWORDS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEPS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rsync_q[SYNC_STAGES-1];

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  quad_t             chain_q, chain_d, work_q, work_d, step_out;
  logic              fin_q, fin_d, ready_q, ready_d;
  logic              capture;
  word_t             stored, step_msg;

  assign capture  = (phase_q == PH_LOAD) && ack && !init;
  assign step_msg = (phase_q == PH_LOAD) ? word_in : stored;

  md5_msg_store #(.DEPTH(NWORDS), .W(WORD_W)) u_store (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (en),
    .we    (capture),
    .waddr (step_q[WIDX_W-1:0]),
    .wdata (word_in),
    .raddr (word_sel(step_q)),
    .rdata (stored)
  );

  md5_step u_step (
    .cur (work_q),
    .msg (step_msg),
    .idx (step_q),
    .nxt (step_out)
  );

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    chain_d = chain_q;
    work_d  = work_q;
    fin_d   = fin_q;
    ready_d = ready_q;
    if (init) begin
      phase_d = PH_LOAD;
      step_d  = '0;
      chain_d = SEED;
      work_d  = SEED;
      fin_d   = 1'b0;
      ready_d = 1'b0;
    end else begin
      case (phase_q)
        PH_LOAD: if (ack) begin
          work_d = step_out;
          step_d = step_q + 1'b1;
          if (step_q == LAST_LOAD) begin
            phase_d = PH_RUN;
            fin_d   = last_blk;
          end
        end
        PH_RUN: begin
          work_d = step_out;
          step_d = step_q + 1'b1;
          if (step_q == LAST_STEP) phase_d = PH_FOLD;
        end
        PH_FOLD: begin
          chain_d.a = chain_q.a + work_q.a;
          chain_d.b = chain_q.b + work_q.b;
          chain_d.c = chain_q.c + work_q.c;
          chain_d.d = chain_q.d + work_q.d;
          work_d    = chain_d;
          step_d    = '0;
          phase_d   = PH_LOAD;
          ready_d   = ready_q | fin_q;
        end
        default: phase_d = PH_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q <= PH_LOAD;
      step_q  <= '0;
      chain_q <= '0;
      work_q  <= '0;
      fin_q   <= 1'b0;
      ready_q <= 1'b0;
    end else if (en) begin
      phase_q <= phase_d;
      step_q  <= step_d;
      chain_q <= chain_d;
      work_q  <= work_d;
      fin_q   <= fin_d;
      ready_q <= ready_d;
    end
  end

  assign req   = (phase_q == PH_LOAD);
  assign ready = ready_q;
  assign dig_a = chain_q.a;
  assign dig_b = chain_q.b;
  assign dig_c = chain_q.c;
  assign dig_d = chain_q.d;
endmodule

// File: rtl/md5_compress_chk.sv
`timescale 1ns/1ps
module md5_compress_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        init,
  input logic        ack,
  input logic        req,
  input logic        ready,
  input logic [31:0] dig_a,
  input logic [31:0] dig_b,
  input logic [31:0] dig_c,
  input logic [31:0] dig_d
);
  logic [6:0] low_cnt;
  logic [3:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      wcnt    <= '0;
    end else if (en) begin
      if (req)                  low_cnt <= '0;
      else if (low_cnt != 7'h7f) low_cnt <= low_cnt + 1'b1;
      if (init)                 wcnt <= '0;
      else if (req && ack)      wcnt <= wcnt + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (req && !ready && dig_a == '0 && dig_b == '0 &&
                                dig_c == '0 && dig_d == '0);
    end
  end

  a_r2_init_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (en && init) |=> (dig_a == 32'h67452301 && dig_b == 32'hefcdab89 &&
                      dig_c == 32'h98badcfe && dig_d == 32'h10325476 && !ready && req));

  a_r4_busy_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !init && req && ack && wcnt == 4'd15) |=> !req);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && !$past(en && init)) |-> low_cnt == 7'd49);

  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ready && !init) |=> ready);

  a_r6_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> req);

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(req) && $stable(ready) && $stable(dig_a) && $stable(dig_b) &&
             $stable(dig_c) && $stable(dig_d)));
endmodule

bind md5_compress md5_compress_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .init  (init),
  .ack   (ack),
  .req   (req),
  .ready (ready),
  .dig_a (dig_a),
  .dig_b (dig_b),
  .dig_c (dig_c),
  .dig_d (dig_d)
);

// File: tb/sim_md5_compress.sv
`timescale 1ns/1ps
module sim_md5_compress;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        en = 1'b1, init = 1'b0, ack = 1'b0, last_blk = 1'b0;
  logic [31:0] word_in = '0;
  logic        req, ready;
  logic [31:0] dig_a, dig_b, dig_c, dig_d;

  int n_chk = 0, n_fail = 0;
  logic [127:0] exp_q[$];
  logic [7:0]   msg[$];
  logic [31:0]  pw[$];
  logic         rdy_prev = 1'b0;
  logic         done = 1'b0;

  localparam logic [127:0] SEED_Q = {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476};

  always #2.5 clk = ~clk;

  md5_compress u0 (.clk(clk), .rst_n(rst_n), .en(en), .init(init), .ack(ack),
                   .word_in(word_in), .last_blk(last_blk), .req(req), .ready(ready),
                   .dig_a(dig_a), .dig_b(dig_b), .dig_c(dig_c), .dig_d(dig_d));

  function automatic logic [127:0] dig();
    return {dig_a, dig_b, dig_c, dig_d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // upstream front end: byte padding plus 64-bit bit length, packed little-endian
  task automatic build(input string s);
    logic [63:0] bits;
    msg.delete();
    pw.delete();
    for (int i = 0; i < s.len(); i++) msg.push_back(s[i]);
    bits = 64'(s.len()) * 64'd8;
    msg.push_back(8'h80);
    while (msg.size() % 64 != 56) msg.push_back(8'h00);
    for (int i = 0; i < 8; i++) msg.push_back(bits[8*i +: 8]);
    for (int i = 0; i < msg.size(); i += 4)
      pw.push_back({msg[i+3], msg[i+2], msg[i+1], msg[i]});
  endtask

  task automatic do_init();
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
  endtask

  task automatic send_block(input int base, input bit fin, input int frz, input bit junk,
                            output int lowcnt);
    for (int k = 0; k < 16; k++) begin
      word_in  = pw[base+k];
      ack      = 1'b1;
      last_blk = fin && (k == 15);
      @(negedge clk);
    end
    ack = junk;
    last_blk = junk;
    lowcnt = 0;
    while (!req && lowcnt < 200) begin
      if (junk) word_in = 32'hdead0000 + 32'(lowcnt);
      en = !(lowcnt >= 10 && lowcnt < 10 + frz);
      lowcnt++;
      @(negedge clk);
    end
    en = 1'b1;
    ack = 1'b0;
    last_blk = 1'b0;
  endtask

  task automatic run_msg(input string s, input logic [127:0] expd, input int frz, input bit junk);
    int lc;
    int nblk;
    build(s);
    nblk = pw.size() / 16;
    do_init();
    chk(dig() == SEED_Q && !ready && req, "R2 init seed", dig(), SEED_Q);
    exp_q.push_back(expd);
    for (int b = 0; b < nblk; b++) begin
      send_block(b * 16, b == nblk - 1, frz, junk, lc);
      chk(lc == 49 + frz, "R4/R7 busy window", 128'(lc), 128'(49 + frz));
      if (b != nblk - 1) chk(!ready, "R6 no ready mid-message", 128'(ready), 128'd0);
    end
  endtask

  // scoreboard monitor: compare each finished message with the queued answer
  always @(negedge clk) begin
    if (ready && !rdy_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected ready", dig(), '0);
      end else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        chk(dig() == e, "R5/R8/R9 digest", dig(), e);
      end
    end
    rdy_prev = ready;
  end

  initial begin
    logic [127:0] held;
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(req && !ready && dig() == '0, "R1 reset state", {dig()}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 + R3: empty message, ack held high with junk while busy
    run_msg("", {32'hd98c1dd4, 32'h04b2008f, 32'h980980e9, 32'h7e42f8ec}, 0, 1'b1);
    @(negedge clk);
    chk(ready, "R6 ready raised", 128'(ready), 128'd1);
    held = dig();
    repeat (8) @(negedge clk);
    chk(ready && dig() == held, "R6 ready sticky", dig(), held);

    // R2: partial block discarded by init; R9 + R7 on "abc" with a 5-cycle freeze
    do_init();
    build("zzzz");
    for (int k = 0; k < 5; k++) begin
      word_in = pw[k]; ack = 1'b1; @(negedge clk);
    end
    ack = 1'b0;
    chk(!ready, "R2 ready cleared", 128'(ready), 128'd0);
    run_msg("abc", {32'h98500190, 32'hb04fd23c, 32'h7d3f96d6, 32'h727fe128}, 5, 1'b0);
    @(negedge clk);

    // R5: two-block message
    run_msg("12345678901234567890123456789012345678901234567890123456789012345678901234567890",
            {32'ha2f4ed57, 32'h55c9e32b, 32'h2eda49ac, 32'h7ab60721}, 0, 1'b0);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all digests seen", 128'(exp_q.size()), 128'd0);

    // R1: reset in the middle of a block
    do_init();
    build("abc");
    for (int k = 0; k < 7; k++) begin
      word_in = pw[k]; ack = 1'b1; @(negedge clk);
    end
    ack = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req && !ready && dig() == '0, "R1 reset mid-block", dig(), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req && !ready, "R1 idle after release", {126'd0, req, ready}, 128'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule